// File: doc/BRIEF.md
# Lane-Counted PHY Power Sequencer

This block powers a shared multi-lane PHY up and down in response to per-lane enable and disable requests. It keeps a count of lanes that are currently enabled. The first enable, which moves the count from zero to one, runs the full power-up routine:

- take the PHY out of reset;
- clear every lane's idle control;
- poll the PLL until it reports lock;
- select the fixed-rate PLL mode;
- turn on the 100 MHz reference output;
- wait for that output to be ungated;
- wait for the PLL to lock again.

An enable that arrives while other lanes are already active only raises the count. A disable idles only the lane that asked. Reset is applied again only when the last lane has gone.

Requests use a valid/ready handshake, and a request is taken when both are high at a clock edge. Ready is high only while no power-up routine is running. A request that arrives during a routine is back-pressured, so the requester must hold valid and the request fields steady until ready returns. Requests are therefore served one at a time.

Every request ends with a one-cycle `done` pulse and a result code. The codes are 0 for success, 1 for an initial-lock timeout, 2 for an output-gate timeout, 3 for a relock timeout and 4 for a disable while no lane is active. The PHY's configuration space is reached through a strobe port: a write presents address and data with `cfg_wr`, and a read presents the address with `cfg_rd`. For a read, the PHY returns the data on `cfg_rdata` in the following cycle and holds it there.

Top module: `phy_seq`

## Requirements
- R1: After reset, `phy_rst_n` is 0, every lane idle bit is 1, `done`, `err`, `cfg_wr` and `cfg_rd` are 0, `err_code` is 0 and `req_ready` is 1.
- R2: `req_ready` is low from the cycle after a first enable is accepted until the cycle its `done` is shown. A request held during that time is accepted on the first edge where ready is high again.
- R3: On a first enable, `phy_rst_n` goes to 1 in the cycle after acceptance. In the cycle after that, every bit of `lane_idle_ctl` is 0. No configuration access is made while `phy_rst_n` is 0.
- R4: PLL lock is polled by reading address 0x10 and testing bit 1, where 1 means locked. Consecutive reads of one wait are exactly `POLL_GAP` cycles apart.
- R5: Once the initial lock is seen, the block writes 0x8 (bit 3) to address 0x10 and then 0x8 (bit 3) to address 0x12. Both writes come before any read of address 0x12.
- R6: The block then reads address 0x12 until bit 2 is 0 (ungated), and then reads address 0x10 until bit 1 is 1. Other read bits are ignored. It then signals `done` with code 0.
- R7: Each wait allows at most `MAX_POLLS` reads, and a pass on the last allowed read counts as success. If that last read fails, the block signals `done` with `err` and code 1, 2 or 3 for the stage, and makes no further accesses. The count stays at one and `phy_rst_n` stays 1.
- R8: An enable while the count is non-zero raises the count, makes no configuration access, leaves `phy_rst_n` unchanged and shows `done` with code 0 in the cycle after acceptance.
- R9: A disable while the count is non-zero sets only idle bit `lane+3` of the requesting lane and lowers the count. It shows `done` with code 0 in the cycle after acceptance. If the count reaches zero, `phy_rst_n` is 0 in that same cycle.
- R10: A disable while the count is zero shows `done` and `err` with code 4 in the cycle after acceptance, and changes neither the idle bits nor the reset.
- R11: `err_code` holds its value until the next request is accepted. `err` is a one-cycle pulse, high together with `done` whenever the code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lane request present |
| req_ready | output | 1 | Block can take a request |
| req_enable | input | 1 | 1 = enable lane, 0 = disable lane |
| req_lane | input | LANE_W | Requesting lane index |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion carried a non-zero code |
| err_code | output | 3 | Result code of the last request |
| phy_rst_n | output | 1 | PHY reset, 0 = held in reset |
| lane_idle_ctl | output | LANES+3 | Idle control word, lane n at bit n+3, bits 2:0 zero |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_addr | output | 6 | Configuration address |
| cfg_wdata | output | 4 | Configuration write data |
| cfg_rdata | input | 4 | Read data, valid the cycle after `cfg_rd` |

## Verification
The bench uses a PHY model whose lock and gate responses can each be told to fail a set number of times. This probes the retry boundary. With 99 failures the sequence must succeed on read 100, and with endless failures it must stop after exactly 100 reads with the right stage code. An off-by-one retry counter would either report a timeout one read early or poll one read too many. The model sets unrelated bits in its read data, so a block that tests the wrong bit locks falsely or never locks. The model also flags writes in the wrong order or a gate poll before the reference write.

Disables at a zero count must report code 4 and leave the PHY alone, where a careless counter would wrap and idle a lane. The bench runs a random mix of enables and disables against a bench-side count and idle word. This shows that only the first enable touches the configuration port and that reset returns exactly when the count reaches zero. A request held during a running sequence must see ready stay low and then be served right after completion, so a design that dropped or doubled it is caught.

// File: rtl/phy_seq_pkg.sv
`timescale 1ns/1ps
package phy_seq_pkg;
  localparam int CFG_AW    = 6;
  localparam int CFG_DW    = 4;
  localparam int IDLE_BASE = 3;
  localparam logic [CFG_AW-1:0] PLL_REG = 6'h10;
  localparam logic [CFG_AW-1:0] REF_REG = 6'h12;
  localparam int LOCK_BIT  = 1;
  localparam int GATE_BIT  = 2;
  localparam int MODE_BIT  = 3;

  typedef enum logic [2:0] {
    CODE_OK       = 3'd0,
    CODE_LOCK     = 3'd1,
    CODE_GATE     = 3'd2,
    CODE_RELOCK   = 3'd3,
    CODE_UNPAIRED = 3'd4
  } seq_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNIDLE,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_GAP,
    ST_SET_RATE,
    ST_SET_REF
  } seq_state_e;
endpackage

// File: rtl/phy_seq_lane_book.sv
`timescale 1ns/1ps
module phy_seq_lane_book
  import phy_seq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 4,
  localparam int LANE_W = $clog2(LANES),
  localparam int IDLE_W = LANES + IDLE_BASE
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_on,
  input  logic              unidle_all,
  input  logic              add_ref,
  input  logic              drop_ref,
  input  logic [LANE_W-1:0] drop_lane,
  output logic [CNT_W-1:0]  act_cnt,
  output logic              phy_rst_n,
  output logic [IDLE_W-1:0] idle_ctl
);
  logic [LANES-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt   <= '0;
      phy_rst_n <= 1'b0;
    end else if (power_on) begin
      act_cnt   <= CNT_W'(1);
      phy_rst_n <= 1'b1;
    end else if (add_ref) begin
      act_cnt   <= act_cnt + CNT_W'(1);
    end else if (drop_ref) begin
      act_cnt   <= act_cnt - CNT_W'(1);
      if (act_cnt == CNT_W'(1)) phy_rst_n <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        idle_q[g] <= 1'b1;
      else if (unidle_all)
        idle_q[g] <= 1'b0;
      else if (drop_ref && (drop_lane == LANE_W'(g)))
        idle_q[g] <= 1'b1;
    end
  end

  assign idle_ctl = {idle_q, {IDLE_BASE{1'b0}}};
endmodule

// File: rtl/phy_seq_poll_timer.sv
`timescale 1ns/1ps
module phy_seq_poll_timer #(
  parameter int POLL_GAP  = 1000,
  parameter int MAX_POLLS = 100,
  localparam int GAP_W = $clog2(POLL_GAP + 1),
  localparam int TRY_W = $clog2(MAX_POLLS + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic stage_start,
  input  logic gap_load,
  input  logic gap_run,
  output logic gap_over,
  output logic last_try
);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP - 3);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_POLLS - 1);

  logic [GAP_W-1:0] gap_q;
  logic [TRY_W-1:0] tries_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_q <= '0;
    else if (gap_load)
      gap_q <= GAP_LOAD;
    else if (gap_run && (gap_q != '0))
      gap_q <= gap_q - GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tries_q <= '0;
    else if (stage_start)
      tries_q <= '0;
    else if (gap_load)
      tries_q <= tries_q + TRY_W'(1);
  end

  assign gap_over = (gap_q == '0);
  assign last_try = (tries_q == TRY_LAST);
endmodule

// File: rtl/phy_seq_cfg_drive.sv
`timescale 1ns/1ps
module phy_seq_cfg_drive
  import phy_seq_pkg::*;
(
  input  seq_state_e         state,
  input  seq_code_e          stage,
  input  logic [CFG_DW-1:0]  rdata,
  output logic               cfg_wr,
  output logic               cfg_rd,
  output logic [CFG_AW-1:0]  cfg_addr,
  output logic [CFG_DW-1:0]  cfg_wdata,
  output logic               poll_ok
);
  logic unused_rbits;

  always_comb begin
    cfg_rd    = (state == ST_POLL_RD);
    cfg_wr    = (state == ST_SET_RATE) || (state == ST_SET_REF);
    cfg_wdata = cfg_wr ? CFG_DW'(1 << MODE_BIT) : '0;
    if (state == ST_SET_REF)
      cfg_addr = REF_REG;
    else if (state == ST_SET_RATE)
      cfg_addr = PLL_REG;
    else if (stage == CODE_GATE)
      cfg_addr = REF_REG;
    else
      cfg_addr = PLL_REG;
    if (stage == CODE_GATE)
      poll_ok = !rdata[GATE_BIT];
    else
      poll_ok = rdata[LOCK_BIT];
  end

  assign unused_rbits = ^{rdata[0], rdata[3]};
endmodule

// File: rtl/phy_seq.sv
`timescale 1ns/1ps
module phy_seq
  import phy_seq_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int CNT_W     = 4,
  parameter int POLL_GAP  = 1000,
  parameter int MAX_POLLS = 100,
  localparam int LANE_W = $clog2(LANES),
  localparam int IDLE_W = LANES + IDLE_BASE
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_enable,
  input  logic [LANE_W-1:0] req_lane,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code,
  output logic              phy_rst_n,
  output logic [IDLE_W-1:0] lane_idle_ctl,
  output logic              cfg_wr,
  output logic              cfg_rd,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [CFG_DW-1:0] cfg_wdata,
  input  logic [CFG_DW-1:0] cfg_rdata
);
  seq_state_e       state_q, state_d;
  seq_code_e        stage_q, stage_d, code_q, code_d;
  logic             done_q, done_d;
  logic             fire, cnt_zero, poll_ok, gap_over, last_try;
  logic             first_up, add_ref, drop_ref, unpaired;
  logic             stage_start, gap_load, gap_run;
  logic [CNT_W-1:0] act_cnt;

  assign req_ready = (state_q == ST_IDLE);
  assign fire      = req_valid && req_ready;
  assign cnt_zero  = (act_cnt == '0);
  assign first_up  = fire &&  req_enable &&  cnt_zero;
  assign add_ref   = fire &&  req_enable && !cnt_zero;
  assign drop_ref  = fire && !req_enable && !cnt_zero;
  assign unpaired  = fire && !req_enable &&  cnt_zero;
  assign gap_run   = (state_q == ST_GAP);

  always_comb begin
    state_d     = state_q;
    stage_d     = stage_q;
    code_d      = code_q;
    done_d      = 1'b0;
    stage_start = 1'b0;
    gap_load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fire) begin
          code_d = CODE_OK;
          if (first_up) begin
            state_d = ST_UNIDLE;
          end else if (unpaired) begin
            done_d = 1'b1;
            code_d = CODE_UNPAIRED;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_UNIDLE: begin
        state_d     = ST_POLL_RD;
        stage_d     = CODE_LOCK;
        stage_start = 1'b1;
      end
      ST_POLL_RD: state_d = ST_POLL_CHK;
      ST_POLL_CHK: begin
        if (poll_ok) begin
          case (stage_q)
            CODE_LOCK: state_d = ST_SET_RATE;
            CODE_GATE: begin
              state_d     = ST_POLL_RD;
              stage_d     = CODE_RELOCK;
              stage_start = 1'b1;
            end
            default: begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          endcase
        end else if (last_try) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          code_d  = stage_q;
        end else begin
          state_d  = ST_GAP;
          gap_load = 1'b1;
        end
      end
      ST_GAP: if (gap_over) state_d = ST_POLL_RD;
      ST_SET_RATE: state_d = ST_SET_REF;
      ST_SET_REF: begin
        state_d     = ST_POLL_RD;
        stage_d     = CODE_GATE;
        stage_start = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= CODE_LOCK;
      code_q  <= CODE_OK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      code_q  <= code_d;
      done_q  <= done_d;
    end
  end

  assign done     = done_q;
  assign err      = done_q && (code_q != CODE_OK);
  assign err_code = code_q;

  phy_seq_lane_book #(
    .LANES (LANES),
    .CNT_W (CNT_W)
  ) u_book (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_on   (first_up),
    .unidle_all (state_q == ST_UNIDLE),
    .add_ref    (add_ref),
    .drop_ref   (drop_ref),
    .drop_lane  (req_lane),
    .act_cnt    (act_cnt),
    .phy_rst_n  (phy_rst_n),
    .idle_ctl   (lane_idle_ctl)
  );

  phy_seq_poll_timer #(
    .POLL_GAP  (POLL_GAP),
    .MAX_POLLS (MAX_POLLS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_start (stage_start),
    .gap_load    (gap_load),
    .gap_run     (gap_run),
    .gap_over    (gap_over),
    .last_try    (last_try)
  );

  phy_seq_cfg_drive u_cfg (
    .state     (state_q),
    .stage     (stage_q),
    .rdata     (cfg_rdata),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .poll_ok   (poll_ok)
  );
endmodule

// File: rtl/phy_seq_chk.sv
`timescale 1ns/1ps
module phy_seq_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = 4,
  localparam int IDLE_W = LANES + 3
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_enable,
  input logic              done,
  input logic              err,
  input logic [2:0]        err_code,
  input logic              phy_rst_n,
  input logic [IDLE_W-1:0] lane_idle_ctl,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [CNT_W-1:0]  act_cnt
);
  logic fire;
  assign fire = req_valid && req_ready;

  AST_CFG_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cfg_rd) |-> phy_rst_n); // R3
  AST_UNIDLE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |=> (lane_idle_ctl == '0)); // R3
  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> !cfg_rd); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cfg_rd) |-> !req_ready); // R2
  AST_ERR_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && (err_code != 3'd0) && (err_code <= 3'd4))); // R11
  AST_LATER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_enable && (act_cnt != '0)) |=> (done && !err && phy_rst_n)); // R8
  AST_LAST_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_enable && (act_cnt == CNT_W'(1))) |=> (!phy_rst_n && done && !err)); // R9
  AST_UNPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_enable && (act_cnt == '0)) |=>
      (err && (err_code == 3'd4) && $stable(lane_idle_ctl) && !phy_rst_n)); // R10
endmodule

bind phy_seq phy_seq_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/phy_seq_tb.sv
`timescale 1ns/1ps
module phy_seq_tb;
  localparam int LANES = 4;
  localparam int GAP   = 5;
  localparam int MAXP  = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_enable = 1'b0;
  logic [1:0] req_lane = '0;
  logic       req_ready, done, err, phy_rst_n, cfg_wr, cfg_rd;
  logic [2:0] err_code;
  logic [6:0] lane_idle_ctl;
  logic [5:0] cfg_addr;
  logic [3:0] cfg_wdata;
  logic [3:0] cfg_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  int need1 = 0, need2 = 0, need3 = 0;
  logic mdl_clr = 1'b0;
  int lock1_rd = 0, gate_rd = 0, lock2_rd = 0;
  int rd_total = 0, wr_total = 0, wr_bad = 0, gate_early = 0, acc_in_rst = 0;
  int t1 = 0, t2 = 0;
  logic rate_seen = 1'b0, ref_seen = 1'b0;

  phy_seq #(.LANES(LANES), .CNT_W(4), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_enable(req_enable), .req_lane(req_lane), .done(done), .err(err),
    .err_code(err_code), .phy_rst_n(phy_rst_n), .lane_idle_ctl(lane_idle_ctl),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  // PHY model: lock/gate reply after a set number of failing reads
  always @(posedge clk) begin
    if (mdl_clr) begin
      lock1_rd <= 0; gate_rd <= 0; lock2_rd <= 0;
      rate_seen <= 1'b0; ref_seen <= 1'b0;
    end else begin
      if ((cfg_rd || cfg_wr) && !phy_rst_n) acc_in_rst <= acc_in_rst + 1;
      if (cfg_rd) begin
        rd_total <= rd_total + 1;
        if (cfg_addr == 6'h10) begin
          if (!rate_seen) begin
            cfg_rdata <= {2'b11, (lock1_rd >= need1), 1'b1};
            if (lock1_rd == 0) t1 <= cyc;
            if (lock1_rd == 1) t2 <= cyc;
            lock1_rd <= lock1_rd + 1;
          end else begin
            cfg_rdata <= {2'b11, (lock2_rd >= need3), 1'b1};
            lock2_rd <= lock2_rd + 1;
          end
        end else if (cfg_addr == 6'h12) begin
          cfg_rdata <= {1'b1, (gate_rd < need2), 2'b01};
          if (!ref_seen) gate_early <= gate_early + 1;
          gate_rd <= gate_rd + 1;
        end else begin
          wr_bad <= wr_bad + 1;
        end
      end
      if (cfg_wr) begin
        wr_total <= wr_total + 1;
        if (cfg_addr == 6'h10 && cfg_wdata == 4'h8 && !rate_seen && !ref_seen)
          rate_seen <= 1'b1;
        else if (cfg_addr == 6'h12 && cfg_wdata == 4'h8 && rate_seen && !ref_seen)
          ref_seen <= 1'b1;
        else
          wr_bad <= wr_bad + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_phy(input int a, input int b, input int c);
    @(negedge clk);
    need1 = a; need2 = b; need3 = c;
    mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;
  endtask

  task automatic issue(input logic en, input logic [1:0] ln);
    @(negedge clk);
    req_valid = 1'b1; req_enable = en; req_lane = ln;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [2:0] code, output int lat);
    lat = 0;
    code = '0;
    do begin
      @(negedge clk);
      lat = lat + 1;
    end while (!done && lat < 3000);
    code = err_code;
    if (lat >= 3000) chk("done never seen", 0, 1);
  endtask

  task automatic bring_up(input int a, input int b, input int c, input logic [1:0] ln,
                          output logic [2:0] code);
    int lat;
    set_phy(a, b, c);
    issue(1'b1, ln);
    @(negedge clk);
    chk("R3 reset released", {31'd0, phy_rst_n}, 1);
    @(negedge clk);
    chk("R3 lanes un-idled", {25'd0, lane_idle_ctl}, 0);
    wait_done(code, lat);
  endtask

  initial begin
    logic [2:0] code;
    int lat, refs, rd0, wr0;
    logic [6:0] exp_idle;
    void'($urandom(32'h5EED1234));

    repeat (3) @(negedge clk);
    chk("R1 reset phy_rst_n", {31'd0, phy_rst_n}, 0);
    chk("R1 reset idle", {25'd0, lane_idle_ctl}, 32'h78);
    chk("R1 reset done/err/strobes", {28'd0, done, err, cfg_wr, cfg_rd}, 0);
    chk("R1 reset code/ready", {28'd0, err_code, req_ready}, 1);
    rst_n = 1'b1;

    // unpaired disable
    issue(1'b0, 2'd2);
    wait_done(code, lat);
    chk("R10 latency", lat, 1);
    chk("R10 err", {31'd0, err}, 1);
    chk("R10 code", {29'd0, code}, 4);
    chk("R10 idle unchanged", {25'd0, lane_idle_ctl}, 32'h78);
    chk("R10 reset unchanged", {31'd0, phy_rst_n}, 0);

    // first bring-up with a request held during the sequence
    set_phy(20, 2, 3);
    issue(1'b1, 2'd0);
    @(negedge clk);
    chk("R3 reset released", {31'd0, phy_rst_n}, 1);
    req_valid = 1'b1; req_enable = 1'b1; req_lane = 2'd1;
    lat = 0;
    begin
      int busy_ready;
      busy_ready = 0;
      while (!done && lat < 3000) begin
        if (req_ready) busy_ready = busy_ready + 1;
        @(negedge clk);
        lat = lat + 1;
      end
      chk("R2 ready low while busy", busy_ready, 0);
    end
    chk("R6 first bring-up code", {29'd0, err_code}, 0);
    chk("R4 lock reads", lock1_rd, 21);
    chk("R4 poll spacing", t2 - t1, GAP);
    chk("R6 gate reads", gate_rd, 3);
    chk("R6 relock reads", lock2_rd, 4);
    chk("R5 writes in order", {30'd0, rate_seen, ref_seen}, 3);
    chk("R5 no bad writes", wr_bad, 0);
    chk("R5 no gate read before ref write", gate_early, 0);
    chk("R2 ready after done", {31'd0, req_ready}, 1);
    rd0 = rd_total; wr0 = wr_total;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R2 held request served", {31'd0, done}, 1);
    chk("R8 later enable code", {29'd0, err_code}, 0);
    chk("R8 no cfg access", (rd_total - rd0) + (wr_total - wr0), 0);
    chk("R8 reset unchanged", {31'd0, phy_rst_n}, 1);
    chk("R11 err is a pulse", {31'd0, err}, 0);

    // disable one of two lanes
    issue(1'b0, 2'd1);
    wait_done(code, lat);
    chk("R9 latency", lat, 1);
    chk("R9 only lane1 idled", {25'd0, lane_idle_ctl}, 32'h10);
    chk("R9 reset kept", {31'd0, phy_rst_n}, 1);
    issue(1'b0, 2'd0);
    wait_done(code, lat);
    chk("R9 last disable resets", {31'd0, phy_rst_n}, 0);
    chk("R9 idle after last", {25'd0, lane_idle_ctl}, 32'h18);

    // random mix
    refs = 0;
    exp_idle = 7'h18;
    for (int i = 0; i < 80; i++) begin
      logic en;
      logic [1:0] ln;
      en = 1'($urandom_range(0, 1));
      ln = 2'($urandom_range(0, 3));
      if (refs >= 6) en = 1'b0;
      if (en && refs == 0) begin
        bring_up(int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
                 int'($urandom_range(0, 6)), ln, code);
        chk("R6 random bring-up code", {29'd0, code}, 0);
        refs = 1;
        exp_idle = '0;
      end else begin
        rd0 = rd_total; wr0 = wr_total;
        issue(en, ln);
        wait_done(code, lat);
        chk("R8/R9/R10 random latency", lat, 1);
        chk("R8 random no cfg access", (rd_total - rd0) + (wr_total - wr0), 0);
        if (!en && refs == 0) begin
          chk("R10 random code", {29'd0, code}, 4);
        end else begin
          chk("R8/R9 random code", {29'd0, code}, 0);
          if (en) refs = refs + 1;
          else begin
            refs = refs - 1;
            exp_idle[ln + 3] = 1'b1;
          end
        end
      end
      chk("R9 random idle word", {25'd0, lane_idle_ctl}, {25'd0, exp_idle});
      chk("R9 random reset", {31'd0, phy_rst_n}, (refs != 0) ? 1 : 0);
    end
    while (refs > 0) begin
      issue(1'b0, 2'd3);
      wait_done(code, lat);
      refs = refs - 1;
    end
    chk("R9 drained reset", {31'd0, phy_rst_n}, 0);

    // timeouts per stage
    bring_up(1000, 0, 0, 2'd0, code);
    chk("R7 lock timeout code", {29'd0, code}, 1);
    chk("R7 lock timeout err", {31'd0, err}, 1);
    chk("R7 lock read count", lock1_rd, MAXP);
    chk("R7 no write after timeout", {31'd0, rate_seen}, 0);
    chk("R7 reset kept after error", {31'd0, phy_rst_n}, 1);
    repeat (4) @(negedge clk);
    chk("R11 code held", {29'd0, err_code}, 1);
    chk("R11 err dropped", {31'd0, err}, 0);
    issue(1'b0, 2'd0);
    wait_done(code, lat);
    chk("R7 count one after error", {31'd0, phy_rst_n}, 0);
    chk("R11 code cleared by request", {29'd0, code}, 0);

    bring_up(0, 1000, 0, 2'd1, code);
    chk("R7 gate timeout code", {29'd0, code}, 2);
    chk("R7 gate read count", gate_rd, MAXP);
    issue(1'b0, 2'd1);
    wait_done(code, lat);

    bring_up(0, 0, 1000, 2'd2, code);
    chk("R7 relock timeout code", {29'd0, code}, 3);
    chk("R7 relock read count", lock2_rd, MAXP);
    issue(1'b0, 2'd2);
    wait_done(code, lat);

    bring_up(MAXP - 1, MAXP - 1, 0, 2'd3, code);
    chk("R7 pass on last read", {29'd0, code}, 0);
    chk("R7 boundary lock reads", lock1_rd, MAXP);
    chk("R7 boundary gate reads", gate_rd, MAXP);
    chk("R3 no access in reset", acc_in_rst, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule